// File: doc/BRIEF.md
# Single-Wire Bus Identity Enumerator

This block is the master-side engine that lists every 64-bit device identity present on a shared single-wire, open-drain bus. It does not generate slot timing. Instead, it issues slot requests (bus reset, write one bit, read one bit) to a separate timing layer. That layer answers each request with an acknowledge strobe and the sampled wired-AND level of the line.

One `start` pulse launches a complete enumeration. Each pass has four steps:

1. The engine resets the bus and checks for a presence answer.
2. It sends the configured search command byte.
3. It walks the 64 identity positions. At each position it reads the bit, reads the complement, and then writes back the chosen direction.
4. At the end of the pass, it presents the completed identity with a one-cycle strobe.

Between passes, the engine remembers the highest position where it resolved a conflict by choosing 0. The next pass takes 1 there. As a result, identities appear in ascending order when each identity is read least-significant bit first as the most significant key.

The search command is a parameter. The same engine therefore serves both the plain search and the variant in which only devices with their output switched on take part. Enumeration ends with a done flag. If no presence answer is seen, or a position reads 1 then 1, the run ends with an error flag.

Top module: `onewire_enum_master`

## Requirements
- R1: After reset the block is idle: `busy`, `slot_req`, `id_valid`, `enum_done` and `no_dev_err` are all 0.
- R2: Every pass opens with a reset request (`slot_op` = 0). If the acknowledged reset returns `slot_rbit` = 1 (no presence), the run stops with `no_dev_err` = 1 and `enum_done` = 0.
- R3: After each acknowledged reset, the engine issues CMD_BITS write requests (`slot_op` = 1) that carry CMD_CODE least significant bit first on `slot_wbit`.
- R4: For each of the ID_BITS positions, the engine issues exactly read (`slot_op` = 2), read, write, in that order. The first read is the true bit, the second is the complement.
- R5: When the two reads differ, the write carries the value of the first read.
- R6: When both reads are 0 (conflict), the write follows these rules:
  - It is 1 at the position where the previous pass last chose 0.
  - It repeats the previous pass's bit below that position.
  - It is 0 above that position and in the first pass.
  - Consequently, identities are reported in ascending bit-reversed order.
- R7: After the write at the last position is acknowledged, `id_valid` pulses for exactly one cycle. At that moment, `id_value` bit i equals the value written at position i (position 0 first on the bus).
- R8: A pass in which no conflict was resolved with 0 ends the run: `enum_done` goes to 1 in the cycle after that pass's `id_valid`, `busy` falls, and the number of reported identities equals the number of taking-part devices.
- R9: A read pair of 1 then 1 aborts the pass: no write follows, no identity is reported for that pass, `no_dev_err` = 1 and `busy` = 0.
- R10: `start` while `busy` = 1 has no effect on the request sequence or the result.
- R11: A request stays asserted, with `slot_op` and `slot_wbit` unchanged, until `slot_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a full enumeration (ignored while busy) |
| busy | output | 1 | Enumeration in progress |
| slot_req | output | 1 | Slot request pending |
| slot_op | output | 2 | Requested slot: 0 reset, 1 write, 2 read |
| slot_wbit | output | 1 | Bit value for a write slot |
| slot_ack | input | 1 | One-cycle completion strobe from the timing layer |
| slot_rbit | input | 1 | Sampled line level: read result, or 0 for presence after reset |
| id_valid | output | 1 | One-cycle strobe, identity complete |
| id_value | output | 64 | Identity found in the current pass, bit 0 sent first |
| enum_done | output | 1 | All identities reported (sticky until next start) |
| no_dev_err | output | 1 | No presence or no participant (sticky until next start) |

## Verification
The bench builds the engine with CMD_CODE = ECh and the default 64-bit identity and 8-bit command. Its bus model is therefore the active-only flavour, where devices whose output is off stay silent during reads yet still answer presence. This puts three cases within reach:
- Enumeration of a filtered subset of devices.
- The 1-then-1 abort, from a population that answers presence but has no participants.
- Populations whose only difference is at the first or the last bus position, which exercise the branch memory at both ends of the pass.

// File: rtl/owe_pkg.sv
package owe_pkg;
  typedef enum logic [1:0] {
    OP_RESET = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2
  } slot_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RST,
    ST_CMD,
    ST_RDA,
    ST_RDB,
    ST_WR,
    ST_REPORT
  } eng_state_e;
endpackage

// File: rtl/owe_branch_pick.sv
module owe_branch_pick #(
  parameter int DISC_W = 7
) (
  input  logic              bit_a,
  input  logic              bit_b,
  input  logic [DISC_W-1:0] pos,
  input  logic [DISC_W-1:0] last_disc,
  input  logic              prev_bit,
  output logic              dir,
  output logic              took_zero,
  output logic              none_left
);
  logic conflict;

  always_comb begin
    none_left = bit_a & bit_b;
    conflict  = ~bit_a & ~bit_b;
    if (!conflict) begin
      dir = bit_a;
    end else if (pos < last_disc) begin
      dir = prev_bit;
    end else if (pos == last_disc) begin
      dir = 1'b1;
    end else begin
      dir = 1'b0;
    end
    took_zero = conflict & ~dir;
  end
endmodule

// File: rtl/owe_id_store.sv
module owe_id_store #(
  parameter int ID_BITS = 64,
  parameter int POS_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [POS_W-1:0]   wr_pos,
  input  logic               wr_bit,
  input  logic [POS_W-1:0]   rd_pos,
  output logic               rd_bit,
  output logic [ID_BITS-1:0] id_q
);
  for (genvar g = 0; g < ID_BITS; g++) begin : g_cell
    logic b_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        b_q <= 1'b0;
      end else if (wr_en && (wr_pos == POS_W'(g))) begin
        b_q <= wr_bit;
      end
    end
    assign id_q[g] = b_q;
  end

  assign rd_bit = id_q[rd_pos];
endmodule

// File: rtl/onewire_enum_master.sv
module onewire_enum_master
  import owe_pkg::*;
#(
  parameter int               ID_BITS  = 64,
  parameter int               CMD_BITS = 8,
  parameter logic [CMD_BITS-1:0] CMD_CODE = 8'hF0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  output logic               busy,
  output logic               slot_req,
  output logic [1:0]         slot_op,
  output logic               slot_wbit,
  input  logic               slot_ack,
  input  logic               slot_rbit,
  output logic               id_valid,
  output logic [ID_BITS-1:0] id_value,
  output logic               enum_done,
  output logic               no_dev_err
);
  localparam int POS_W  = $clog2(ID_BITS);
  localparam int DISC_W = $clog2(ID_BITS + 1);
  localparam int CNT_W  = (CMD_BITS > 1) ? $clog2(CMD_BITS) : 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  eng_state_e        state_q, state_d;
  logic [POS_W-1:0]  idx_q, idx_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              bit_a_q, bit_a_d;
  logic              dir_q, dir_d;
  logic [DISC_W-1:0] last_disc_q, last_disc_d;
  logic [DISC_W-1:0] last_zero_q, last_zero_d;
  logic              done_q, done_d;
  logic              err_q, err_d;
  logic              store_en;
  logic [DISC_W-1:0] pos1;
  logic              pick_dir, pick_zero, pick_none, prev_bit;

  assign pos1 = DISC_W'(idx_q) + DISC_W'(1);

  owe_branch_pick #(.DISC_W(DISC_W)) u_pick (
    .bit_a     (bit_a_q),
    .bit_b     (slot_rbit),
    .pos       (pos1),
    .last_disc (last_disc_q),
    .prev_bit  (prev_bit),
    .dir       (pick_dir),
    .took_zero (pick_zero),
    .none_left (pick_none)
  );

  owe_id_store #(.ID_BITS(ID_BITS), .POS_W(POS_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .wr_en  (store_en),
    .wr_pos (idx_q),
    .wr_bit (pick_dir),
    .rd_pos (idx_q),
    .rd_bit (prev_bit),
    .id_q   (id_value)
  );

  always_comb begin
    state_d     = state_q;
    idx_d       = idx_q;
    cnt_d       = cnt_q;
    bit_a_d     = bit_a_q;
    dir_d       = dir_q;
    last_disc_d = last_disc_q;
    last_zero_d = last_zero_q;
    done_d      = done_q;
    err_d       = err_q;
    store_en    = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        state_d     = ST_RST;
        last_disc_d = '0;
        done_d      = 1'b0;
        err_d       = 1'b0;
      end
      ST_RST: if (slot_ack) begin
        if (slot_rbit) begin
          err_d   = 1'b1;
          state_d = ST_IDLE;
        end else begin
          state_d     = ST_CMD;
          cnt_d       = '0;
          idx_d       = '0;
          last_zero_d = '0;
        end
      end
      ST_CMD: if (slot_ack) begin
        if (cnt_q == CNT_W'(CMD_BITS - 1)) state_d = ST_RDA;
        else                               cnt_d   = cnt_q + CNT_W'(1);
      end
      ST_RDA: if (slot_ack) begin
        bit_a_d = slot_rbit;
        state_d = ST_RDB;
      end
      ST_RDB: if (slot_ack) begin
        if (pick_none) begin
          err_d   = 1'b1;
          state_d = ST_IDLE;
        end else begin
          dir_d    = pick_dir;
          store_en = 1'b1;
          if (pick_zero) last_zero_d = pos1;
          state_d  = ST_WR;
        end
      end
      ST_WR: if (slot_ack) begin
        if (idx_q == POS_W'(ID_BITS - 1)) begin
          state_d = ST_REPORT;
        end else begin
          idx_d   = idx_q + POS_W'(1);
          state_d = ST_RDA;
        end
      end
      ST_REPORT: begin
        last_disc_d = last_zero_q;
        if (last_zero_q == '0) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          state_d = ST_RST;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q     <= ST_IDLE;
      idx_q       <= '0;
      cnt_q       <= '0;
      bit_a_q     <= 1'b0;
      dir_q       <= 1'b0;
      last_disc_q <= '0;
      last_zero_q <= '0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      state_q     <= state_d;
      idx_q       <= idx_d;
      cnt_q       <= cnt_d;
      bit_a_q     <= bit_a_d;
      dir_q       <= dir_d;
      last_disc_q <= last_disc_d;
      last_zero_q <= last_zero_d;
      done_q      <= done_d;
      err_q       <= err_d;
    end
  end

  always_comb begin
    slot_req  = 1'b0;
    slot_op   = OP_RESET;
    slot_wbit = 1'b0;
    unique case (state_q)
      ST_RST: begin
        slot_req = 1'b1;
        slot_op  = OP_RESET;
      end
      ST_CMD: begin
        slot_req  = 1'b1;
        slot_op   = OP_WRITE;
        slot_wbit = CMD_CODE[cnt_q];
      end
      ST_RDA, ST_RDB: begin
        slot_req = 1'b1;
        slot_op  = OP_READ;
      end
      ST_WR: begin
        slot_req  = 1'b1;
        slot_op   = OP_WRITE;
        slot_wbit = dir_q;
      end
      default: ;
    endcase
  end

  assign busy       = (state_q != ST_IDLE);
  assign id_valid   = (state_q == ST_REPORT);
  assign enum_done  = done_q;
  assign no_dev_err = err_q;
endmodule

// File: rtl/owe_check.sv
module owe_check (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       slot_req,
  input logic [1:0] slot_op,
  input logic       slot_wbit,
  input logic       slot_ack,
  input logic       id_valid,
  input logic       enum_done,
  input logic       no_dev_err
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!slot_req && !id_valid));

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_req && !slot_ack) |=> (slot_req && $stable(slot_op) && $stable(slot_wbit)));

  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid |=> !id_valid);

  assert_done_after_id_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enum_done) |-> ($past(id_valid) && !busy));

  assert_err_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(no_dev_err) |-> (!busy && !enum_done));

  assert_flags_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(enum_done && no_dev_err));
endmodule

bind onewire_enum_master owe_check u_owe_check (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .slot_req   (slot_req),
  .slot_op    (slot_op),
  .slot_wbit  (slot_wbit),
  .slot_ack   (slot_ack),
  .id_valid   (id_valid),
  .enum_done  (enum_done),
  .no_dev_err (no_dev_err)
);

// File: tb/onewire_enum_master_tb_top.sv
module onewire_enum_master_tb_top;
  localparam logic [7:0] CMD = 8'hEC;
  localparam int LAT = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic slot_ack = 1'b0;
  logic slot_rbit = 1'b1;
  logic busy, slot_req, slot_wbit, id_valid, enum_done, no_dev_err;
  logic [1:0] slot_op;
  logic [63:0] id_value;

  always #2 clk = ~clk;

  onewire_enum_master #(.ID_BITS(64), .CMD_BITS(8), .CMD_CODE(CMD)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .slot_req(slot_req), .slot_op(slot_op), .slot_wbit(slot_wbit),
    .slot_ack(slot_ack), .slot_rbit(slot_rbit), .id_valid(id_valid),
    .id_value(id_value), .enum_done(enum_done), .no_dev_err(no_dev_err)
  );

  int total = 0;
  int bad = 0;

  // bus population model
  logic [63:0] dev_id [8];
  bit          dev_on [8];
  bit          sel    [8];
  int          ndev = 0;
  logic [63:0] exp_q[$];
  int          found = 0;
  bit          need_reset = 1'b1;
  bit          in_cmd = 1'b0;
  int          wcnt = 0;
  int          step = 0;
  int          pos = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] rev64(input logic [63:0] v);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) r[i] = v[63-i];
    return r;
  endfunction

  task automatic build_expect();
    logic [63:0] t;
    exp_q.delete();
    for (int k = 0; k < ndev; k++) if (dev_on[k]) exp_q.push_back(dev_id[k]);
    for (int i = 0; i < exp_q.size(); i++)
      for (int j = 0; j + 1 < exp_q.size() - i; j++)
        if (rev64(exp_q[j]) > rev64(exp_q[j+1])) begin
          t = exp_q[j]; exp_q[j] = exp_q[j+1]; exp_q[j+1] = t;
        end
  endtask

  // slot responder and request-sequence reference
  task automatic serve(output logic r);
    logic a;
    r = 1'b1;
    if (slot_op == 2'd0) begin
      check(need_reset, "R2 reset only at pass start", 64'(slot_op), 64'd0);
      for (int k = 0; k < 8; k++) sel[k] = (k < ndev) && dev_on[k];
      r = (ndev == 0);
      need_reset = 1'b0; in_cmd = 1'b1; wcnt = 0; step = 0; pos = 0;
    end else if (slot_op == 2'd1) begin
      check(!need_reset, "R2 write before reset", 64'(slot_op), 64'd0);
      if (in_cmd) begin
        check(slot_wbit == CMD[wcnt], "R3 command bit", 64'(slot_wbit), 64'(CMD[wcnt]));
        wcnt++;
        if (wcnt == 8) in_cmd = 1'b0;
      end else begin
        check(step == 2, "R4 write after two reads", 64'(step), 64'd2);
        if (found < exp_q.size())
          check(slot_wbit == exp_q[found][pos], "R5 R6 written direction",
                64'(slot_wbit), 64'(exp_q[found][pos]));
        for (int k = 0; k < 8; k++) if (sel[k] && dev_id[k][pos] != slot_wbit) sel[k] = 1'b0;
        pos++; step = 0;
        if (pos == 64) need_reset = 1'b1;
      end
    end else begin
      check(!need_reset && !in_cmd && step < 2, "R4 read order", 64'(step), 64'd0);
      for (int k = 0; k < 8; k++)
        if (sel[k]) begin
          a = dev_id[k][pos];
          if (step == 1) a = ~a;
          r = r & a;
        end
      step++;
    end
  endtask

  initial begin
    logic r;
    forever begin
      @(negedge clk);
      if (slot_req) begin
        repeat (LAT) @(negedge clk);
        serve(r);
        slot_rbit = r;
        slot_ack = 1'b1;
        @(negedge clk);
        slot_ack = 1'b0;
        slot_rbit = 1'b1;
      end
    end
  end

  // identity strobe compared on every clock
  always @(negedge clk) begin
    if (rst_n && id_valid) begin
      if (found < exp_q.size())
        check(id_value == exp_q[found], "R7 R6 reported identity", id_value, exp_q[found]);
      else
        check(1'b0, "R7 unexpected identity", id_value, 64'd0);
      found++;
    end
  end

  task automatic run(input bit expect_err, input bit poke_start, input string tag);
    build_expect();
    found = 0; need_reset = 1'b1; in_cmd = 1'b0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (poke_start) begin   // R10: start while busy
      repeat (300) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
      repeat (900) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    while (busy) @(negedge clk);
    @(negedge clk);
    if (expect_err) begin
      check(no_dev_err == 1'b1, {tag, " R9 R2 error flag"}, 64'(no_dev_err), 64'd1);
      check(enum_done == 1'b0, {tag, " R9 no done"}, 64'(enum_done), 64'd0);
      check(found == 0, {tag, " R9 no identity"}, 64'(found), 64'd0);
    end else begin
      check(enum_done == 1'b1, {tag, " R8 done flag"}, 64'(enum_done), 64'd1);
      check(no_dev_err == 1'b0, {tag, " R8 no error"}, 64'(no_dev_err), 64'd0);
      check(found == exp_q.size(), {tag, " R8 identity count"}, 64'(found), 64'(exp_q.size()));
    end
    check(!busy && !slot_req, {tag, " R1 idle after run"}, 64'(busy), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy && !slot_req && !id_valid && !enum_done && !no_dev_err,
          "R1 reset state", {59'd0, busy, slot_req, id_valid, enum_done, no_dev_err}, 64'd0);

    // four devices differing in low positions
    ndev = 4;
    dev_id[0] = 64'h3C00_1122_3344_55AC; dev_on[0] = 1;
    dev_id[1] = 64'h3C00_1122_3344_5555; dev_on[1] = 1;
    dev_id[2] = 64'h3C00_1122_3344_55AF; dev_on[2] = 1;
    dev_id[3] = 64'h3C00_1122_3344_5588; dev_on[3] = 1;
    run(1'b0, 1'b1, "four");

    // differ only at the last bus position
    ndev = 2;
    dev_id[0] = 64'h8123_4567_89AB_CD05; dev_on[0] = 1;
    dev_id[1] = 64'h0123_4567_89AB_CD05; dev_on[1] = 1;
    run(1'b0, 1'b0, "top");

    // single device, no conflict
    ndev = 1;
    dev_id[0] = 64'hA5A5_0F0F_F0F0_5A05; dev_on[0] = 1;
    run(1'b0, 1'b0, "single");

    // active-only filter: one device silent
    ndev = 3;
    dev_id[0] = 64'h1111_0000_0000_0005; dev_on[0] = 1;
    dev_id[1] = 64'h1111_0000_0000_0004; dev_on[1] = 0;
    dev_id[2] = 64'h2222_0000_0000_0006; dev_on[2] = 1;
    run(1'b0, 1'b0, "filter");

    // present but none taking part: 1-then-1 abort
    ndev = 2;
    dev_on[0] = 0; dev_on[1] = 0;
    run(1'b1, 1'b0, "silent");

    // empty bus: no presence
    ndev = 0;
    run(1'b1, 1'b0, "empty");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule